// File: doc/BRIEF.md
# Clockless Sub-Band Serial Receiver

This receiver takes a three-wire serial stream made of a word-select line, a data line and a packet reference line. No bit clock comes with the stream. It rebuilds the bit timing from a fast local clock by counting system clocks per bit. On every word-select transition it re-aligns that count, so the drift between the sender's rate and the local rate never builds up over more than one word slot. The nominal line rate is 768 kbit/s, and each word-select level lasts 32 bit times.

Only the first sixteen bits of each slot carry payload. A low slot supplies the upper two bytes of a 32-bit longword and the following high slot supplies the lower two bytes. When a longword is complete, the block presents it with a single-cycle valid strobe. A start flag on that strobe reports that a rising edge on the reference line was seen since the previous longword. A high slot with no complete low slot in front of it produces a one-cycle error pulse instead of a longword. Searching for audio frame sync and decoding the payload are left to downstream logic.

Top module: `subband_rx`

## Requirements
- R1: After reset all outputs are 0, and no longword or error is produced until the first word-select transition.
- R2: Bits arrive most significant first. After a word-select transition, bit 0 belongs to the previous word and bits 1 to 16 are payload. The low-slot payload appears on `lword_o[31:16]` and the high-slot payload on `lword_o[15:0]`, each MSB first.
- R3: Bit 0 and bits 17 onward of every slot have no effect on the longword.
- R4: `lword_valid_o` is a single-cycle pulse that rises 16·N + N/2 + 4 clocks after the raw word-select rise of the high slot, where N is `CLKS_PER_BIT`. `lword_o` changes only in a cycle where `lword_valid_o` is 1.
- R5: `lword_sop_o` is 1 together with a longword exactly when a rising edge on `pkt_ref_i` occurred after the previous longword. It is never 1 without `lword_valid_o`.
- R6: A high slot completing its 16 payload bits without a complete low slot since the last longword gives a one-cycle `half_err_o` pulse and no longword. A pending start flag is kept for the next longword.
- R7: The bit counter restarts on every word-select transition. Slots of any length of at least 17 bit times decode correctly, and so do bit times that alternate between N−1 and N+1 clocks.
- R8: A slot cut short by a word-select transition before its 16th payload bit contributes nothing. If it was a low slot, the high slot that follows reports an error under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ws_i | input | 1 | Word-select line, asynchronous; low marks bytes 0–1, high marks bytes 2–3 |
| sd_i | input | 1 | Serial data line, asynchronous, MSB first |
| pkt_ref_i | input | 1 | Packet reference pulse, asynchronous |
| lword_o | output | 32 | Assembled longword, byte 0 in bits 31:24 |
| lword_valid_o | output | 1 | One-cycle strobe for a new longword |
| lword_sop_o | output | 1 | Start-of-packet flag qualified by the strobe |
| half_err_o | output | 1 | One-cycle pulse for a high slot with no low slot |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 16, so one longword takes about a thousand clocks and dozens of them fit in the run. At that ratio, a bit time that alternates by ±1 clock still keeps the sampling point inside bit 16, which tests the per-edge realignment. Slot lengths are drawn between 17 and 40 bits, and the fill bits are forced to the opposite of the payload. Directed cases cover truncated slots, a high slot first after reset, and reference pulses that must carry past an error.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;
  localparam int PAY_BITS = 16;
  localparam int IDX_W    = 6;
  typedef logic [PAY_BITS-1:0] half_t;
endpackage

// File: rtl/sbrx_sync.sv
module sbrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/sbrx_bit_timer.sv
module sbrx_bit_timer
  import sbrx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 325
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_s,
  output logic sample_o,
  output logic last_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [CW-1:0]    cnt_q, cnt_n;
  logic [IDX_W-1:0] bit_q, bit_n;
  logic             ws_d_q;
  logic             edge_w, wrap_w, in_pay_w;

  assign edge_w   = ws_s ^ ws_d_q;
  assign wrap_w   = (cnt_q == CW'(CLKS_PER_BIT - 1));
  assign in_pay_w = (bit_q >= IDX_W'(1)) && (bit_q <= IDX_W'(PAY_BITS));

  always_comb begin
    cnt_n = cnt_q;
    bit_n = bit_q;
    if (edge_w) begin
      cnt_n = '0;
      bit_n = '0;
    end else if (wrap_w) begin
      cnt_n = '0;
      if (bit_q != '1) bit_n = bit_q + IDX_W'(1);
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= '1;
      ws_d_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      ws_d_q <= ws_s;
    end
  end

  assign sample_o = !edge_w && in_pay_w && (cnt_q == CW'(HALF));
  assign last_o   = (bit_q == IDX_W'(PAY_BITS));
endmodule

// File: rtl/sbrx_assembler.sv
module sbrx_assembler
  import sbrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_i,
  input  logic        last_i,
  input  logic        ws_s,
  input  logic        sd_s,
  input  logic        ref_s,
  output logic [31:0] lword_o,
  output logic        valid_o,
  output logic        sop_o,
  output logic        err_o
);
  logic [PAY_BITS-2:0] shift_q, shift_n;
  half_t               low_q, low_n, full_w;
  logic                have_low_q, have_low_n;
  logic                ref_d_q, seen_q, seen_n, rise_w;
  logic [31:0]         word_n;
  logic                valid_n, sop_n, err_n, done_w;

  assign full_w = {shift_q, sd_s};
  assign rise_w = ref_s && !ref_d_q;
  assign done_w = sample_i && last_i;

  always_comb begin
    shift_n    = shift_q;
    low_n      = low_q;
    have_low_n = have_low_q;
    word_n     = lword_o;
    valid_n    = 1'b0;
    sop_n      = 1'b0;
    err_n      = 1'b0;
    seen_n     = seen_q | rise_w;
    if (sample_i) shift_n = full_w[PAY_BITS-2:0];
    if (done_w) begin
      if (!ws_s) begin
        low_n      = full_w;
        have_low_n = 1'b1;
      end else begin
        have_low_n = 1'b0;
        if (have_low_q) begin
          word_n  = {low_q, full_w};
          valid_n = 1'b1;
          sop_n   = seen_q | rise_w;
          seen_n  = 1'b0;
        end else begin
          err_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      low_q      <= '0;
      have_low_q <= 1'b0;
      ref_d_q    <= 1'b0;
      seen_q     <= 1'b0;
      lword_o    <= '0;
      valid_o    <= 1'b0;
      sop_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      shift_q    <= shift_n;
      low_q      <= low_n;
      have_low_q <= have_low_n;
      ref_d_q    <= ref_s;
      seen_q     <= seen_n;
      lword_o    <= word_n;
      valid_o    <= valid_n;
      sop_o      <= sop_n;
      err_o      <= err_n;
    end
  end
endmodule

// File: rtl/subband_rx.sv
module subband_rx #(
  parameter int CLKS_PER_BIT = 325
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic        pkt_ref_i,
  output logic [31:0] lword_o,
  output logic        lword_valid_o,
  output logic        lword_sop_o,
  output logic        half_err_o
);
  logic       rst_meta_q, rst_sync_q;
  logic [2:0] sync_w;
  logic       sample_w, last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sbrx_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   ({pkt_ref_i, sd_i, ws_i}),
    .q_o   (sync_w)
  );

  sbrx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ws_s     (sync_w[0]),
    .sample_o (sample_w),
    .last_o   (last_w)
  );

  sbrx_assembler u_asm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sample_i (sample_w),
    .last_i   (last_w),
    .ws_s     (sync_w[0]),
    .sd_s     (sync_w[1]),
    .ref_s    (sync_w[2]),
    .lword_o  (lword_o),
    .valid_o  (lword_valid_o),
    .sop_o    (lword_sop_o),
    .err_o    (half_err_o)
  );
endmodule

// File: rtl/subband_rx_chk.sv
module subband_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] lword_o,
  input logic        lword_valid_o,
  input logic        lword_sop_o,
  input logic        half_err_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lword_valid_o |=> !lword_valid_o); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lword_o) |-> lword_valid_o); // R4
  AST_SOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    lword_sop_o |-> lword_valid_o); // R5
  AST_ERR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    half_err_o |-> !lword_valid_o); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    half_err_o |=> !half_err_o); // R6
endmodule

bind subband_rx subband_rx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lword_o       (lword_o),
  .lword_valid_o (lword_valid_o),
  .lword_sop_o   (lword_sop_o),
  .half_err_o    (half_err_o)
);

// File: tb/subband_rx_tb_top.sv
module subband_rx_tb_top;
  localparam int N    = 16;
  localparam int HALF = N / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b0, sd = 1'b0, pref = 1'b0;
  logic [31:0] lword;
  logic        lvalid, lsop, herr;

  int checks = 0, fails = 0;
  int cyc = 0, edge_cyc = 0;
  int wr = 0, rd = 0, exp_err = 0, seen_err = 0;
  logic [31:0] exp_w [0:255];
  logic        exp_s [0:255];
  bit          pend = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  subband_rx #(.CLKS_PER_BIT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ws_i(ws), .sd_i(sd), .pkt_ref_i(pref),
    .lword_o(lword), .lword_valid_o(lvalid), .lword_sop_o(lsop), .half_err_o(herr)
  );

  function automatic logic [31:0] join_word(input logic [15:0] lo, input logic [15:0] hi);
    return {lo, hi};
  endfunction

  function automatic logic fill_bit(input int mode);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'b0;
    return 1'($urandom);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && lvalid) begin
      if (rd >= wr) check("R4 unexpected longword", lword, 32'hx);
      else begin
        check("R2 R3 longword value", lword, exp_w[rd]);
        check("R5 start flag", 32'(lsop), 32'(exp_s[rd]));
        check("R4 latency in window", 32'((cyc - edge_cyc >= 16*N+HALF+2) && (cyc - edge_cyc <= 16*N+HALF+6)), 32'd1);
        rd++;
      end
    end
    if (rst_n && herr) seen_err++;
  end

  // one slot: level lvl, payload pay, nbits bit times, ref pulse at bit ref_at (-1 none)
  task automatic send_half(input logic lvl, input logic [15:0] pay, input int nbits,
                           input int ref_at, input bit jit, input int fmode);
    ws = lvl;
    if (lvl) edge_cyc = cyc;
    for (int b = 0; b < nbits; b++) begin
      int len;
      len = jit ? ((b % 2) ? N + 1 : N - 1) : N;
      sd = (b >= 1 && b <= 16) ? pay[16-b] : fill_bit(fmode);
      pref = (b == ref_at);
      if (b == ref_at) pend = 1'b1;
      repeat (len) @(negedge clk);
    end
    pref = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] lo, input logic [15:0] hi, input int nlo,
                           input int nhi, input int ref_at, input bit jit, input int fmode);
    send_half(1'b0, lo, nlo, ref_at, jit, fmode);
    exp_w[wr] = join_word(lo, hi);
    exp_s[wr] = pend;
    pend = 1'b0;
    wr++;
    send_half(1'b1, hi, nhi, -1, jit, fmode);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check("R1 reset lword", lword, 32'd0);
    check("R1 reset strobes", {29'd0, lvalid, lsop, herr}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      sd = 1'($urandom);
      pref = (i == 50);
      @(negedge clk);
    end
    pref = 1'b0;
    check("R1 quiet before first word-select edge", 32'(rd + seen_err), 32'd0);
    // ref pulse above must stay pending; first slot is high -> error R6
    pend = 1'b1;
    send_half(1'b1, 16'hABCD, 32, -1, 1'b0, 0);
    exp_err++;
    check("R6 error on high slot first", 32'(seen_err), 32'(exp_err));
    check("R6 no longword on error", 32'(rd), 32'd0);
    // R3 fill opposite to payload
    send_word(16'h0000, 16'h0000, 32, 32, -1, 1'b0, 1);
    send_word(16'hFFFF, 16'hFFFF, 32, 32, -1, 1'b0, 2);
    // R5 ref then none
    send_word(16'h1234, 16'h5678, 32, 32, 3, 1'b0, 0);
    send_word(16'h9ABC, 16'hDEF0, 32, 32, -1, 1'b0, 0);
    // R8 truncated low slot, ref carried past the error (R6)
    send_half(1'b0, 16'hAAAA, 10, 2, 1'b0, 0);
    send_half(1'b1, 16'h5555, 32, -1, 1'b0, 0);
    exp_err++;
    send_word(16'hC3C3, 16'h3C3C, 32, 32, -1, 1'b0, 0);
    // R8 truncated high slot produces nothing
    send_half(1'b0, 16'h0F0F, 32, -1, 1'b0, 0);
    send_half(1'b1, 16'hF0F0, 12, -1, 1'b0, 0);
    send_word(16'h8001, 16'h7FFE, 17, 17, -1, 1'b1, 0);
    // R7 random slot lengths and jitter
    for (int i = 0; i < 40; i++) begin
      send_word(16'($urandom), 16'($urandom), 17 + int'($urandom % 24), 17 + int'($urandom % 24),
                (($urandom % 4) == 0) ? int'($urandom % 8) : -1, 1'($urandom), int'($urandom % 3));
    end
    send_half(1'b0, 16'h0, 32, -1, 1'b0, 0);
    repeat (4 * N) @(negedge clk);
    check("R4 R7 all longwords seen", 32'(rd), 32'(wr));
    check("R6 R8 error count", 32'(seen_err), 32'(exp_err));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d longwords", rd, wr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule